// File: doc/BRIEF.md
# Privileged System-Control Register File

This block holds the 32-bit system-control registers of a processor's control coprocessor. Move-to and move-from coprocessor instructions reach one register per request, named by four fields: a primary register number, a first opcode, a secondary register number and a second opcode. All four fields take part in the decode. The request also carries a read/write flag, write data and the current processor mode. Read data and an accepted or unimplemented flag come back in the same cycle. A write lands at the next clock edge.

Privilege gates access. Any mode other than user mode is privileged. User mode reaches only the barrier and prefetch-flush write entries, the shared thread-ID register, and a fixed constant returned in place of the user-read-only thread register. The identification registers are fixed by parameter and no write can change them. Cache, TLB and translation side effects are not modelled. The matching entries are plain storage or are accepted and discarded.

Top module: `sysctl_regfile`

## Requirements
- R1: Decode uses all four fields, opcode1 included. A tuple that differs from a defined entry in any single field is unimplemented. This applies to (crn 1, op1 1, crm 0, op2 0) and to (crn 15, op1 0, crm 5, op2 2).
- R2: Every mode value other than 5'b10000 counts as privileged and gets full access. Examples are 5'b10011, 5'b10010 and 5'b11111.
- R3: A privileged write to a storage entry takes effect at the next clock edge. A read of the same tuple in the following cycle returns the written value. Storage entries:
  - control, auxiliary control and access control at (1,0,0,0..2);
  - translation bases and base control at (2,0,0,0..2);
  - domain access at (3,0,0,0);
  - fault status at (5,0,0,0..1) and fault address at (6,0,0,0..1);
  - TLB lockdown at (10,0,0,0) and region remap at (10,0,2,0..1);
  - process ID and context ID at (13,0,0,0..1), privileged thread ID at (13,0,0,4);
  - monitor control and counters at (15,0,12,0..3);
  - lockdown VA, PA and attribute at (15,5,5..7,2).
- R4: A user-mode write to any entry other than those in R5 is rejected: unimpl_o=1, ack_o=0, and every stored value stays unchanged.
- R5: These writes are accepted in every mode: (7,0,5,4), (7,0,10,4), (7,0,10,5) and the shared thread ID (13,0,0,2). A user-mode write to (13,0,0,2) is stored.
- R6: In user mode, (13,0,0,2) reads the stored shared thread ID. In any mode, (13,0,0,3) reads the parameter USER_RO_CONST.
- R7: A read of an unimplemented tuple, or of one not permitted in the current mode, returns 0 with unimpl_o=1 and ack_o=0. A user-mode read of a privileged entry is one such case.
- R8: The identification entries return words of ID_WORDS in privileged reads, indexed as follows:
  - (0,0,0,op2): op2 0,1,3,5 map to indices 0,1,2,3;
  - (0,0,1,op2): op2 0,1,2 map to indices 4,5,6, and op2 4..7 map to indices 7..10;
  - (0,0,2,op2): op2 0..4 map to indices 11..15.
  A write to any of them is unimplemented and leaves the value unchanged.
- R9: While req_i=1, exactly one of ack_o and unimpl_o is 1. While req_i=0, both are 0.
- R10: Reset clears every storage entry to 0.
- R11: A write to (13,0,0,3) is accepted only in a privileged mode and never changes what that tuple reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| crn_i | input | 4 | Primary register number |
| op1_i | input | 3 | First opcode |
| crm_i | input | 4 | Secondary register number |
| op2_i | input | 3 | Second opcode |
| wdata_i | input | 32 | Write data |
| mode_i | input | 5 | Current processor mode |
| rdata_o | output | 32 | Read data, 0 unless an accepted read |
| ack_o | output | 1 | Access accepted |
| unimpl_o | output | 1 | Access unimplemented or not permitted |

## Verification
The hardest case to reach from the ports is a rejected user-mode write: nothing changes when it happens, so the rejection cannot be seen directly. The bench first loads a distinct value into a storage entry in privileged mode. It then issues the user-mode write with different data and switches back to privileged mode to read the entry. The old value must still be there. The same sequence covers the identification entries and the constant thread entry. Opcode1 decoding is exercised with tuples that match a real entry in every field except one.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W    = 32;
  localparam int MODE_W    = 5;
  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam int NUM_STORE = 25;
  localparam int IDX_W     = $clog2(NUM_STORE);
  localparam int NUM_ID    = 16;

  typedef enum logic [1:0] {SRC_NONE, SRC_STORE, SRC_ID, SRC_CONST} src_e;

  typedef struct packed {
    logic             rd_ok;
    logic             wr_ok;
    logic             usr_rd;
    logic             usr_wr;
    logic             wr_store;
    src_e             src;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic dec_t store_ent(input int unsigned ix, input logic usr);
    dec_t d;
    d          = '0;
    d.rd_ok    = 1'b1;
    d.wr_ok    = 1'b1;
    d.usr_rd   = usr;
    d.usr_wr   = usr;
    d.wr_store = 1'b1;
    d.src      = SRC_STORE;
    d.idx      = IDX_W'(ix);
    return d;
  endfunction

  function automatic dec_t id_ent(input int unsigned ix);
    dec_t d;
    d       = '0;
    d.rd_ok = 1'b1;
    d.src   = SRC_ID;
    d.idx   = IDX_W'(ix);
    return d;
  endfunction

  function automatic dec_t decode_tuple(input logic [3:0] crn, input logic [2:0] op1,
                                        input logic [3:0] crm, input logic [2:0] op2);
    dec_t d;
    logic base;
    d    = '0;
    base = (op1 == 3'd0) && (crm == 4'd0);
    case (crn)
      4'd0: if (op1 == 3'd0) begin
        if (crm == 4'd0) begin
          case (op2)
            3'd0: d = id_ent(0);
            3'd1: d = id_ent(1);
            3'd3: d = id_ent(2);
            3'd5: d = id_ent(3);
            default: ;
          endcase
        end else if (crm == 4'd1) begin
          if (op2 <= 3'd2)      d = id_ent(4 + int'(op2));
          else if (op2 >= 3'd4) d = id_ent(3 + int'(op2));
        end else if (crm == 4'd2 && op2 <= 3'd4) begin
          d = id_ent(11 + int'(op2));
        end
      end
      4'd1: if (base && op2 <= 3'd2) d = store_ent(int'(op2), 1'b0);
      4'd2: if (base && op2 <= 3'd2) d = store_ent(3 + int'(op2), 1'b0);
      4'd3: if (base && op2 == 3'd0) d = store_ent(6, 1'b0);
      4'd5: if (base && op2 <= 3'd1) d = store_ent(7 + int'(op2), 1'b0);
      4'd6: if (base && op2 <= 3'd1) d = store_ent(9 + int'(op2), 1'b0);
      4'd7: if (op1 == 3'd0 && ((crm == 4'd5 && op2 == 3'd4) ||
                                (crm == 4'd10 && (op2 == 3'd4 || op2 == 3'd5)))) begin
        d.wr_ok  = 1'b1;   // barrier / prefetch flush: accepted, no state
        d.usr_wr = 1'b1;
      end
      4'd10: if (op1 == 3'd0) begin
        if (crm == 4'd0 && op2 == 3'd0)      d = store_ent(11, 1'b0);
        else if (crm == 4'd2 && op2 <= 3'd1) d = store_ent(12 + int'(op2), 1'b0);
      end
      4'd13: if (base) begin
        case (op2)
          3'd0: d = store_ent(14, 1'b0);
          3'd1: d = store_ent(15, 1'b0);
          3'd2: d = store_ent(16, 1'b1);
          3'd3: begin
            d.rd_ok  = 1'b1;
            d.usr_rd = 1'b1;
            d.wr_ok  = 1'b1;
            d.src    = SRC_CONST;
          end
          3'd4: d = store_ent(17, 1'b0);
          default: ;
        endcase
      end
      4'd15: begin
        if (op1 == 3'd0 && crm == 4'd12 && op2 <= 3'd3)
          d = store_ent(18 + int'(op2), 1'b0);
        else if (op1 == 3'd5 && op2 == 3'd2 && crm >= 4'd5 && crm <= 4'd7)
          d = store_ent(17 + int'(crm), 1'b0);
      end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic              wr_i,
  input  logic [3:0]        crn_i,
  input  logic [2:0]        op1_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        op2_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              permit_o,
  output logic              store_wr_o,
  output src_e              src_o,
  output logic [IDX_W-1:0]  idx_o
);
  dec_t d;
  logic priv;

  always_comb begin
    d    = decode_tuple(crn_i, op1_i, crm_i, op2_i);
    priv = (mode_i != MODE_USER);
    if (wr_i) permit_o = d.wr_ok && (priv || d.usr_wr);
    else      permit_o = d.rd_ok && (priv || d.usr_rd);
    store_wr_o = d.wr_store;
    src_o      = d.src;
    idx_o      = d.idx;
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = NUM_STORE,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q[g] <= '0;
      else if (wr_en_i && widx_i == IW'(g))        q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(ridx_i) < N) ? q[ridx_i] : '0;

  // R3
  store_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [NUM_ID-1:0][DATA_W-1:0] ID_WORDS = {
    32'h0000_1111, 32'h0111_2131, 32'h0000_2141, 32'h1122_2311, 32'h0140_011F,
    32'h0110_0000, 32'h1020_2000, 32'h0122_0000, 32'h0000_0001, 32'h0110_0004,
    32'h0000_0000, 32'h0000_0002, 32'h0000_0111, 32'h0000_0000, 32'h1D15_2152,
    32'h410F_B020 },
  parameter logic [DATA_W-1:0] USER_RO_CONST = 32'hFF00_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [3:0]        crn_i,
  input  logic [2:0]        op1_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        op2_i,
  input  logic [31:0]       wdata_i,
  input  logic [4:0]        mode_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  output logic              unimpl_o
);
  logic             permit, store_wr;
  src_e             src;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] store_rd;

  sysctl_decode u_dec (
    .wr_i(wr_i), .crn_i(crn_i), .op1_i(op1_i), .crm_i(crm_i), .op2_i(op2_i),
    .mode_i(mode_i), .permit_o(permit), .store_wr_o(store_wr), .src_o(src), .idx_o(idx)
  );

  sysctl_store #(.W(DATA_W), .N(NUM_STORE)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(req_i && wr_i && permit && store_wr),
    .widx_i(idx), .wdata_i(wdata_i), .ridx_i(idx), .rdata_o(store_rd)
  );

  always_comb begin
    ack_o    = req_i && permit;
    unimpl_o = req_i && !permit;
    rdata_o  = '0;
    if (ack_o && !wr_i) begin
      case (src)
        SRC_STORE: rdata_o = store_rd;
        SRC_ID:    rdata_o = ID_WORDS[idx[3:0]];
        SRC_CONST: rdata_o = USER_RO_CONST;
        default:   rdata_o = '0;
      endcase
    end
  end

  // R9
  one_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $onehot({ack_o, unimpl_o}));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !ack_o && !unimpl_o);
  // R7
  reject_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && unimpl_o) |-> rdata_o == '0);
  // R4
  user_write_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && mode_i == MODE_USER && crn_i != 4'd7 && crn_i != 4'd13) |-> unimpl_o);
  // R6
  user_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_i && crn_i == 4'd13 && op1_i == 3'd0 && crm_i == 4'd0 && op2_i == 3'd3)
      |-> ack_o && rdata_o == USER_RO_CONST);
  // R3
  write_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i && wr_i && ack_o && store_wr) && req_i && !wr_i && ack_o &&
     {crn_i, op1_i, crm_i, op2_i} == $past({crn_i, op1_i, crm_i, op2_i}))
      |-> rdata_o == $past(wdata_i));
endmodule

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;
  localparam logic [4:0] USR = 5'b10000, SVC = 5'b10011, IRQ = 5'b10010, SYS = 5'b11111;
  localparam logic [31:0] CONST_V = 32'hC0DE_0200;

  function automatic logic [31:0] idw(input int k);
    return 32'hA500_0000 + 32'(k) * 32'h0001_0101;
  endfunction

  localparam logic [15:0][31:0] IDS = {
    idw(15), idw(14), idw(13), idw(12), idw(11), idw(10), idw(9), idw(8),
    idw(7), idw(6), idw(5), idw(4), idw(3), idw(2), idw(1), idw(0)};

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [3:0] crn = 0, crm = 0;
  logic [2:0] op1 = 0, op2 = 0;
  logic [31:0] wdata = 0, rdata;
  logic [4:0] mode = SVC;
  logic ack, unimpl;
  logic [31:0] g_rd;
  logic g_ack, g_un;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysctl_regfile #(.ID_WORDS(IDS), .USER_RO_CONST(CONST_V)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .crn_i(crn), .op1_i(op1),
    .crm_i(crm), .op2_i(op2), .wdata_i(wdata), .mode_i(mode),
    .rdata_o(rdata), .ack_o(ack), .unimpl_o(unimpl));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access just after a falling edge, sample, return at the next falling edge
  task automatic acc(input logic w, input logic [3:0] n, input logic [2:0] o1,
                     input logic [3:0] m, input logic [2:0] o2, input logic [31:0] d,
                     input logic [4:0] md);
    req = 1; wr = w; crn = n; op1 = o1; crm = m; op2 = o2; wdata = d; mode = md;
    #1;
    g_rd = rdata; g_ack = ack; g_un = unimpl;
    @(negedge clk);
  endtask

  task automatic idle();
    req = 0; wr = 0;
    #1;
    check(!ack && !unimpl, "R9 idle flags", {30'd0, ack, unimpl}, 32'd0);
    @(negedge clk);
  endtask

  task automatic rd_expect(input logic [3:0] n, input logic [2:0] o1, input logic [3:0] m,
                           input logic [2:0] o2, input logic [4:0] md,
                           input logic [31:0] exp, input logic exp_ack, input string tag);
    acc(0, n, o1, m, o2, 32'd0, md);
    check(g_rd == exp, tag, g_rd, exp);
    check(g_ack == exp_ack && g_un == !exp_ack, {tag, " flags"}, {30'd0, g_ack, g_un},
          {30'd0, exp_ack, !exp_ack});
  endtask

  task automatic t_reset();
    rd_expect(1, 0, 0, 0, SVC, 32'd0, 1, "R10 control after reset");
    rd_expect(15, 5, 7, 2, SVC, 32'd0, 1, "R10 lockdown attr after reset");
    rd_expect(13, 0, 0, 2, USR, 32'd0, 1, "R10 shared thread id after reset");
    idle();
  endtask

  task automatic t_priv_rw();
    acc(1, 2, 0, 0, 1, 32'h1234_5678, SVC);
    check(g_ack, "R3 write ack", {31'd0, g_ack}, 32'd1);
    rd_expect(2, 0, 0, 1, SVC, 32'h1234_5678, 1, "R3 back-to-back readback");
    acc(1, 15, 0, 12, 3, 32'hCAFE_0003, SVC);
    acc(1, 15, 5, 6, 2, 32'hBEEF_0006, SVC);
    acc(1, 10, 0, 2, 1, 32'h0BAD_F00D, SVC);
    rd_expect(15, 0, 12, 3, SVC, 32'hCAFE_0003, 1, "R3 event counter");
    rd_expect(15, 5, 6, 2, SVC, 32'hBEEF_0006, 1, "R3 lockdown PA");
    rd_expect(10, 0, 2, 1, SVC, 32'h0BAD_F00D, 1, "R3 region remap");
    rd_expect(2, 0, 0, 0, SVC, 32'd0, 1, "R3 neighbour untouched");
    idle();
  endtask

  task automatic t_modes();
    acc(1, 13, 0, 0, 4, 32'h0000_00A1, IRQ);
    check(g_ack, "R2 irq-mode write", {31'd0, g_ack}, 32'd1);
    rd_expect(13, 0, 0, 4, SYS, 32'h0000_00A1, 1, "R2 sys-mode read");
    rd_expect(13, 0, 0, 4, USR, 32'd0, 0, "R7 user read of privileged thread id");
    idle();
  endtask

  task automatic t_user_blocked();
    acc(1, 1, 0, 0, 0, 32'h0000_5555, SVC);
    acc(1, 1, 0, 0, 0, 32'hFFFF_FFFF, USR);
    check(g_un && !g_ack, "R4 user write rejected", {30'd0, g_ack, g_un}, 32'd1);
    idle();
    rd_expect(1, 0, 0, 0, SVC, 32'h0000_5555, 1, "R4 control unchanged");
    acc(1, 6, 0, 0, 1, 32'h7777_0000, USR);
    check(g_un, "R4 user write fault addr", {31'd0, g_un}, 32'd1);
    rd_expect(6, 0, 0, 1, SVC, 32'd0, 1, "R4 fault addr unchanged");
    idle();
  endtask

  task automatic t_user_paths();
    acc(1, 7, 0, 5, 4, 32'h1, USR);
    check(g_ack, "R5 user prefetch flush", {31'd0, g_ack}, 32'd1);
    acc(1, 7, 0, 10, 4, 32'h0, USR);
    check(g_ack, "R5 user data sync barrier", {31'd0, g_ack}, 32'd1);
    acc(1, 7, 0, 10, 5, 32'h0, USR);
    check(g_ack, "R5 user data memory barrier", {31'd0, g_ack}, 32'd1);
    acc(1, 13, 0, 0, 2, 32'h0004_2000, USR);
    check(g_ack, "R5 user shared thread write", {31'd0, g_ack}, 32'd1);
    rd_expect(13, 0, 0, 2, USR, 32'h0004_2000, 1, "R6 user shared thread read");
    rd_expect(13, 0, 0, 3, USR, CONST_V, 1, "R6 user constant read");
    rd_expect(13, 0, 0, 3, SVC, CONST_V, 1, "R6 privileged constant read");
    rd_expect(7, 0, 10, 4, SVC, 32'd0, 0, "R7 barrier read unimplemented");
    idle();
  endtask

  task automatic t_thread_ro();
    acc(1, 13, 0, 0, 3, 32'h1357_9BDF, SVC);
    check(g_ack, "R11 privileged write accepted", {31'd0, g_ack}, 32'd1);
    rd_expect(13, 0, 0, 3, USR, CONST_V, 1, "R11 read still constant");
    acc(1, 13, 0, 0, 3, 32'h2468_ACE0, USR);
    check(g_un && !g_ack, "R11 user write rejected", {30'd0, g_ack, g_un}, 32'd1);
    idle();
  endtask

  task automatic t_id();
    rd_expect(0, 0, 0, 0, SVC, idw(0), 1, "R8 main id");
    rd_expect(0, 0, 0, 5, SVC, idw(3), 1, "R8 cpu id");
    rd_expect(0, 0, 1, 2, SVC, idw(6), 1, "R8 feature crm1 op2 2");
    rd_expect(0, 0, 1, 7, SVC, idw(10), 1, "R8 feature crm1 op2 7");
    rd_expect(0, 0, 2, 4, SVC, idw(15), 1, "R8 feature crm2 op2 4");
    rd_expect(0, 0, 1, 3, SVC, 32'd0, 0, "R7 gap crm1 op2 3");
    rd_expect(0, 0, 0, 2, SVC, 32'd0, 0, "R7 gap crm0 op2 2");
    acc(1, 0, 0, 0, 0, 32'hDEAD_BEEF, SVC);
    check(g_un, "R8 id write rejected", {31'd0, g_un}, 32'd1);
    idle();
    rd_expect(0, 0, 0, 0, SVC, idw(0), 1, "R8 main id unchanged");
    rd_expect(0, 0, 0, 0, USR, 32'd0, 0, "R7 user read of id");
    idle();
  endtask

  task automatic t_fields();
    acc(1, 1, 0, 0, 1, 32'h0000_AAAA, SVC);
    acc(1, 1, 1, 0, 1, 32'h0000_BBBB, SVC);
    check(g_un, "R1 opcode1=1 write unimpl", {31'd0, g_un}, 32'd1);
    rd_expect(1, 1, 0, 1, SVC, 32'd0, 0, "R1 opcode1=1 read unimpl");
    rd_expect(1, 0, 0, 1, SVC, 32'h0000_AAAA, 1, "R1 opcode1=0 intact");
    rd_expect(15, 0, 5, 2, SVC, 32'd0, 0, "R1 lockdown with opcode1=0");
    rd_expect(1, 0, 1, 1, SVC, 32'd0, 0, "R1 crm mismatch");
    rd_expect(4, 0, 0, 0, SVC, 32'd0, 0, "R7 empty primary number");
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_priv_rw();
    t_modes();
    t_user_blocked();
    t_user_paths();
    t_thread_ro();
    t_id();
    t_fields();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule